// File: doc/BRIEF.md
# Combinational Restoring Array Divider

This block divides one unsigned word by another in a single combinational pass and returns both the quotient and the remainder. It is built as a grid of identical compare-and-subtract cells. Each row of the grid settles one quotient bit, starting with the most significant bit. Each row appends the next dividend bit to the running partial remainder and subtracts the divisor. If no borrow comes out of the subtraction, the row keeps the difference and its quotient bit is 1. Otherwise the row passes its input through unchanged and its quotient bit is 0.

The dividend is handled as a double-width value whose upper half is zero. This is why the first row sees only zeros, one dividend bit and the divisor. The output is valid after the ripple through all rows, so it suits a datapath that gives the divide a full cycle or more. The operand width is a parameter; its default is 32.

Top module: `rad_divider`

## Requirements
- R1: For a nonzero divisor, `quotient_o` equals the floor of `dividend_i / divisor_i`, both operands read as unsigned.
- R2: For a nonzero divisor, `remainder_o` equals `dividend_i mod divisor_i` and is strictly less than `divisor_i`.
- R3: For a nonzero divisor, `quotient_o * divisor_i + remainder_o` equals `dividend_i` when computed at double width.
- R4: When `divisor_i` is zero, `quotient_o` is all ones and `remainder_o` equals `dividend_i`.
- R5: When the dividend is smaller than a nonzero divisor, `quotient_o` is zero and `remainder_o` equals `dividend_i`.
- R6: When `divisor_i` is one, `quotient_o` equals `dividend_i` and `remainder_o` is zero.
- R7: When the dividend equals a nonzero divisor, `quotient_o` is one and `remainder_o` is zero.
- R8: The outputs depend only on the present operands and hold no state. R1 to R7 apply at any width W of 2 or more, including the all-ones operand values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend_i | input | W | Unsigned dividend |
| divisor_i | input | W | Unsigned divisor |
| quotient_o | output | W | Unsigned quotient; all ones for a zero divisor |
| remainder_o | output | W | Unsigned remainder; the dividend for a zero divisor |

## Verification
Whenever the operands are known, the bound checker tests the arithmetic identity, the bound on the remainder, the zero-divisor result, the divide-by-one result and the small-dividend result. It does this at every width the block is instantiated with. Whether the quotient equals the exact floor value for each operand pair, and whether the outputs follow new operands with no memory of earlier ones, can be shown only by the bench. It sweeps every operand pair of a narrow instance and applies corner and random operands to the full-width instance in changing order.

// File: rtl/rad_pkg.sv
package rad_pkg;
  // default operand width of the array divider
  localparam int unsigned RAD_DEFAULT_W = 32;
endpackage

// File: rtl/rad_cell.sv
// One compare-and-subtract cell: a bit of (a - b - bin) with a restore mux.
module rad_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic bin_i,
  input  logic take_i,
  output logic bout_o,
  output logic rem_o
);
  logic diff;

  always_comb begin
    diff   = a_i ^ b_i ^ bin_i;
    bout_o = (~a_i & b_i) | (~(a_i ^ b_i) & bin_i);
    rem_o  = take_i ? diff : a_i;
  end
endmodule

// File: rtl/rad_row.sv
// One divider row: appends a dividend bit, trial-subtracts the divisor,
// and keeps either the difference or the unchanged partial remainder.
module rad_row #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] prem_i,
  input  logic         din_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] prem_o,
  output logic         qbit_o
);
  localparam int unsigned XW = W + 1;

  logic [XW-1:0] xval;
  logic [W:0]    bchain;
  logic          take;

  assign xval      = {prem_i, din_i};
  assign bchain[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_cell
      rad_cell u_cell (
        .a_i    (xval[i]),
        .b_i    (dvs_i[i]),
        .bin_i  (bchain[i]),
        .take_i (take),
        .bout_o (bchain[i+1]),
        .rem_o  (prem_o[i])
      );
    end
  endgenerate

  // Top bit: the divisor is zero there, so a borrow leaves this bit only if
  // a borrow comes in and the appended partial-remainder bit is zero.
  assign take   = xval[XW-1] | ~bchain[W];
  assign qbit_o = take;
endmodule

// File: rtl/rad_divider.sv
module rad_divider #(
  parameter int unsigned W = rad_pkg::RAD_DEFAULT_W
) (
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o
);
  localparam int unsigned ROWS = W;

  // prem[0] is the zero upper half of the double-width dividend
  logic [W-1:0] prem [ROWS+1];

  assign prem[0] = '0;

  genvar r;
  generate
    for (r = 0; r < ROWS; r++) begin : g_row
      rad_row #(.W(W)) u_row (
        .prem_i (prem[r]),
        .din_i  (dividend_i[ROWS-1-r]),
        .dvs_i  (divisor_i),
        .prem_o (prem[r+1]),
        .qbit_o (quotient_o[ROWS-1-r])
      );
    end
  endgenerate

  assign remainder_o = prem[ROWS];
endmodule

// File: rtl/rad_divider_chk.sv
module rad_divider_chk #(
  parameter int unsigned W = 32
) (
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic [W-1:0] quotient_o,
  input logic [W-1:0] remainder_o
);
  localparam int unsigned DW = 2 * W;

  logic [DW-1:0] recon;

  always_comb begin
    recon = {{W{1'b0}}, quotient_o} * {{W{1'b0}}, divisor_i}
          + {{W{1'b0}}, remainder_o};
    if (!$isunknown({dividend_i, divisor_i, quotient_o, remainder_o})) begin
      if (divisor_i != '0) begin
        a_r3_identity: assert (recon == {{W{1'b0}}, dividend_i})
          else $error("R3 identity broken");
        a_r2_rem_bound: assert (remainder_o < divisor_i)
          else $error("R2 remainder not below divisor");
      end
      if (divisor_i == '0) begin
        a_r4_zero_div: assert (quotient_o == '1 && remainder_o == dividend_i)
          else $error("R4 zero divisor result");
      end
      if (divisor_i != '0 && dividend_i < divisor_i) begin
        a_r5_small_dvd: assert (quotient_o == '0 && remainder_o == dividend_i)
          else $error("R5 small dividend result");
      end
      if (divisor_i == W'(1)) begin
        a_r6_div_one: assert (quotient_o == dividend_i && remainder_o == '0)
          else $error("R6 divide by one result");
      end
    end
  end
endmodule

bind rad_divider rad_divider_chk #(.W(W)) u_chk (
  .dividend_i  (dividend_i),
  .divisor_i   (divisor_i),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o)
);

// File: tb/rad_divider_tb.sv
`timescale 1ns/1ps
module rad_divider_tb;
  localparam int unsigned BW = 32;
  localparam int unsigned SW = 6;

  logic clk;
  logic rst_n;
  logic [BW-1:0] a_big, b_big, q_big, r_big;
  logic [SW-1:0] a_sm, b_sm, q_sm, r_sm;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  rad_divider #(.W(BW)) u_dut (
    .dividend_i (a_big), .divisor_i (b_big),
    .quotient_o (q_big), .remainder_o (r_big)
  );

  rad_divider #(.W(SW)) u_small (
    .dividend_i (a_sm), .divisor_i (b_sm),
    .quotient_o (q_sm), .remainder_o (r_sm)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // apply one full-width pair and compare {q,r} against arithmetic
  task automatic big_case(input string req, input logic [BW-1:0] a, input logic [BW-1:0] b);
    logic [BW-1:0] eq, er;
    @(posedge clk);
    a_big = a;
    b_big = b;
    if (b == '0) begin
      eq = '1;
      er = a;
    end else begin
      eq = a / b;
      er = a % b;
    end
    @(negedge clk);
    check(req, {q_big, r_big}, {eq, er});
  endtask

  initial begin
    rst_n = 1'b0;
    a_big = '0; b_big = '0; a_sm = '0; b_sm = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 at the starting state: 0 / 0
    check("R4 initial", {q_big, r_big}, {{BW{1'b1}}, {BW{1'b0}}});

    // R8: exhaustive sweep of the narrow instance (R1 R2 R4 R5 R6 R7)
    for (int a = 0; a < (1 << SW); a++) begin
      for (int b = 0; b < (1 << SW); b++) begin
        logic [SW-1:0] eq, er;
        @(posedge clk);
        a_sm = SW'(a);
        b_sm = SW'(b);
        if (b == 0) begin
          eq = '1;
          er = SW'(a);
        end else begin
          eq = SW'(a / b);
          er = SW'(a % b);
        end
        @(negedge clk);
        check("R8 R1 R2 sweep", {52'd0, q_sm, r_sm}, {52'd0, eq, er});
      end
    end

    big_case("R4 zero divisor", 32'hDEAD_BEEF, 32'd0);
    big_case("R4 zero divisor max", 32'hFFFF_FFFF, 32'd0);
    big_case("R6 divisor one", 32'hFFFF_FFFF, 32'd1);
    big_case("R6 divisor one small", 32'd12345, 32'd1);
    big_case("R5 divisor above dividend", 32'd100, 32'd101);
    big_case("R5 max divisor", 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    big_case("R7 equal operands", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    big_case("R7 equal small", 32'd9, 32'd9);
    big_case("R1 max by two", 32'hFFFF_FFFF, 32'd2);
    big_case("R2 remainder max", 32'hFFFF_FFFE, 32'hFFFF_FFFF);
    big_case("R1 msb divisor", 32'hC000_0001, 32'h8000_0000);
    big_case("R8 zero dividend", 32'd0, 32'd7);

    // R3 R8: random operands, new pair every cycle
    for (int k = 0; k < 300; k++) begin
      logic [BW-1:0] ra, rb;
      ra = $urandom;
      rb = $urandom >> (k % 32);
      big_case("R3 random", ra, rb);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R8 got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule